// File: doc/BRIEF.md
# Character-Cell Text Raster Generator

This block turns a character buffer and a bitmap font into a monochrome raster for a 640x480 monitor mode. It runs from the pixel clock and splits that clock into eight-pixel character slots. In each slot it reads one character code from the text memory, uses that code to fetch one eight-pixel row of the glyph, and loads that row into a shifter. The shifter then sends the row out one pixel per clock, with the most significant bit first. The block also generates both sync pulses, and it forces the picture to black outside the visible area.

A line is 100 slots long, and 80 of those slots are visible. A frame is 525 lines long, and 480 of those lines are visible. That gives 80 columns by 30 rows of 8x16 cells. The line count is kept in an 8-bit counter, an extra high bit, and a blanking flag, and it passes through three phases. Every sync and visibility flag is registered at a slot or line boundary, and its value is taken from the count that the counter is about to show. The two memories have simple synchronous write ports. These ports exist only so the font and the text can be loaded. All timing figures are parameters, so a reduced raster can be built from the same code.

Top module: `vga_text_scan`

## Requirements
- R1: While rst_n is low, hsync_n and vsync_n are high and pixel is low. After release, the scan restarts at tick 0 of column 0 on line 0.
- R2: A character slot lasts 8 clocks. A line lasts H_TOTAL slots (default 100, which is 800 clocks), and columns count up from 0.
- R3: hsync_n is low for every clock of the slots whose column is HS_START to HS_END inclusive (default 82 to 93), and high otherwise.
- R4: A frame has 2^LCW + (P2_LAST+1) + (P3_LAST+1) lines (default 256 + 224 + 45 = 525). The first two phases are the visible lines.
- R5: vsync_n is low on the blanking-phase lines whose count is VS_FIRST to VS_LAST (default lines 490 and 491), and high otherwise.
- R6: The character code for column c of line L is read from text address (L/16)*2^COL_BITS + c (default row*128 + column).
- R7: The glyph byte is read from font address code*16 + (L mod 16). Its bit 7 is shown first.
- R8: The glyph is loaded at tick 2 of its slot. Bit 7-i of the glyph for the slot that starts at clock n appears on pixel at clock n+3+i.
- R9: For a column at or beyond H_VIS, or on a blanking line, pixel stays 0 for that slot's eight pixels, whatever the memories hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| text_we | input | 1 | Text memory write strobe |
| text_waddr | input | TXT_AW | Text memory write address |
| text_wdata | input | 8 | Character code to store |
| font_we | input | 1 | Font memory write strobe |
| font_waddr | input | 12 | Font memory write address (code*16 + glyph row) |
| font_wdata | input | 8 | Glyph row byte to store |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| pixel | output | 1 | Monochrome pixel, 1 = lit |

## Verification
The sync outputs change on the clock edge that starts the slot or line they belong to, because each one is decided one slot early. A slot's pixels, however, come out three clocks after that slot begins: one clock for the text read, one for the font read and one for the shifter load. The bench counts clocks from the release of reset. For each clock it works out the expected sync levels from that clock's own slot and line. For the expected pixel it goes back three clocks to find the slot that owns the pixel. It then samples every output half a period after the edge, so each comparison lands in exactly the clock where the value is due.

// File: rtl/vts_pkg.sv
package vts_pkg;
    localparam int SLOT_PIX   = 8;
    localparam int TICK_W     = $clog2(SLOT_PIX);
    localparam int LOAD_TICK  = 2;
    localparam int GLYPH_ROWS = 16;
    localparam int FROW_W     = $clog2(GLYPH_ROWS);
    localparam int CODE_W     = 8;
    localparam int FONT_AW    = CODE_W + FROW_W;
endpackage

// File: rtl/vts_timing.sv
module vts_timing
    import vts_pkg::*;
#(
    parameter int H_TOTAL  = 100,
    parameter int H_VIS    = 80,
    parameter int HS_START = 82,
    parameter int HS_END   = 93,
    parameter int LCW      = 8,
    parameter int P2_LAST  = 223,
    parameter int P3_LAST  = 44,
    parameter int VS_FIRST = 10,
    parameter int VS_LAST  = 11,
    localparam int HCW     = $clog2(H_TOTAL)
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [TICK_W-1:0] tick,
    output logic [HCW-1:0]    col,
    output logic [LCW:0]      lnum,
    output logic              vis,
    output logic              hsync_n,
    output logic              vsync_n
);
    typedef struct packed {
        logic [TICK_W-1:0] tick;
        logic [HCW-1:0]    col;
        logic [LCW-1:0]    lcnt;
        logic              hi;
        logic              vblank;
        logic              hs_n;
        logic              vs_n;
        logic              hvis;
        logic              vvis;
    } scan_t;

    scan_t st_q, st_d;
    logic [HCW-1:0] col_next;
    logic [LCW-1:0] lcnt_next;
    logic           hi_next, vb_next;

    always_comb begin
        st_d      = st_q;
        col_next  = st_q.col;
        lcnt_next = st_q.lcnt;
        hi_next   = st_q.hi;
        vb_next   = st_q.vblank;
        st_d.tick = st_q.tick + 1'b1;
        if (st_q.tick == TICK_W'(SLOT_PIX - 1)) begin
            col_next  = (st_q.col == HCW'(H_TOTAL - 1)) ? '0 : st_q.col + 1'b1;
            st_d.col  = col_next;
            st_d.hs_n = !((col_next >= HCW'(HS_START)) && (col_next <= HCW'(HS_END)));
            st_d.hvis = (col_next < HCW'(H_VIS));
            if (st_q.col == HCW'(H_TOTAL - 1)) begin
                if (st_q.vblank) begin
                    if (st_q.lcnt == LCW'(P3_LAST)) begin
                        lcnt_next = '0;
                        vb_next   = 1'b0;
                    end else begin
                        lcnt_next = st_q.lcnt + 1'b1;
                    end
                end else if (st_q.hi) begin
                    if (st_q.lcnt == LCW'(P2_LAST)) begin
                        lcnt_next = '0;
                        hi_next   = 1'b0;
                        vb_next   = 1'b1;
                    end else begin
                        lcnt_next = st_q.lcnt + 1'b1;
                    end
                end else begin
                    if (st_q.lcnt == '1) begin
                        hi_next = 1'b1;
                    end
                    lcnt_next = st_q.lcnt + 1'b1;
                end
                st_d.lcnt   = lcnt_next;
                st_d.hi     = hi_next;
                st_d.vblank = vb_next;
                st_d.vvis   = !vb_next;
                st_d.vs_n   = !(vb_next && (lcnt_next >= LCW'(VS_FIRST))
                                        && (lcnt_next <= LCW'(VS_LAST)));
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.tick   <= '0;
            st_q.col    <= '0;
            st_q.lcnt   <= '0;
            st_q.hi     <= 1'b0;
            st_q.vblank <= 1'b0;
            st_q.hs_n   <= 1'b1;
            st_q.vs_n   <= 1'b1;
            st_q.hvis   <= 1'b1;
            st_q.vvis   <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick    = st_q.tick;
    assign col     = st_q.col;
    assign lnum    = {st_q.hi, st_q.lcnt};
    assign vis     = st_q.hvis & st_q.vvis;
    assign hsync_n = st_q.hs_n;
    assign vsync_n = st_q.vs_n;
endmodule

// File: rtl/vts_ram.sv
module vts_ram #(
    parameter int AW = 12,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;
    logic [DW-1:0] mem_q [DEPTH];
    logic [DW-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
        rdata_q <= mem_q[raddr];
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/vts_shifter.sv
module vts_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         vis,
    input  logic [W-1:0] glyph,
    output logic         pixel
);
    typedef struct packed {
        logic [W-1:0] sh;
        logic         on;
    } shf_t;

    shf_t s_q, s_d;

    always_comb begin
        s_d = s_q;
        if (load) begin
            s_d.sh = vis ? glyph : '0;
            s_d.on = vis;
        end else begin
            s_d.sh = {s_q.sh[W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.sh <= '0;
            s_q.on <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pixel = s_q.sh[W-1] & s_q.on;
endmodule

// File: rtl/vga_text_scan.sv
module vga_text_scan
    import vts_pkg::*;
#(
    parameter int H_TOTAL  = 100,
    parameter int H_VIS    = 80,
    parameter int HS_START = 82,
    parameter int HS_END   = 93,
    parameter int LCW      = 8,
    parameter int P2_LAST  = 223,
    parameter int P3_LAST  = 44,
    parameter int VS_FIRST = 10,
    parameter int VS_LAST  = 11,
    parameter int COL_BITS = 7,
    parameter int TXT_AW   = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              text_we,
    input  logic [TXT_AW-1:0] text_waddr,
    input  logic [7:0]        text_wdata,
    input  logic              font_we,
    input  logic [11:0]       font_waddr,
    input  logic [7:0]        font_wdata,
    output logic              hsync_n,
    output logic              vsync_n,
    output logic              pixel
);
    localparam int HCW   = $clog2(H_TOTAL);
    localparam int ROW_W = LCW + 1 - FROW_W;

    logic [TICK_W-1:0] tick_w;
    logic [HCW-1:0]    col_w;
    logic [LCW:0]      lnum_w;
    logic              vis_w;
    logic [ROW_W-1:0]  row_w;
    logic [FROW_W-1:0] frow_w;
    logic [COL_BITS-1:0] colx_w;
    logic [TXT_AW-1:0] taddr_w;
    logic [CODE_W-1:0] code_w;
    logic [FONT_AW-1:0] faddr_w;
    logic [7:0]        glyph_w;
    logic              load_w;

    vts_timing #(
        .H_TOTAL(H_TOTAL), .H_VIS(H_VIS), .HS_START(HS_START), .HS_END(HS_END),
        .LCW(LCW), .P2_LAST(P2_LAST), .P3_LAST(P3_LAST),
        .VS_FIRST(VS_FIRST), .VS_LAST(VS_LAST)
    ) timing_i (
        .clk(clk), .rst_n(rst_n), .tick(tick_w), .col(col_w), .lnum(lnum_w),
        .vis(vis_w), .hsync_n(hsync_n), .vsync_n(vsync_n)
    );

    assign row_w   = lnum_w[LCW:FROW_W];
    assign frow_w  = lnum_w[FROW_W-1:0];
    assign colx_w  = COL_BITS'(col_w);
    assign taddr_w = TXT_AW'({row_w, colx_w});
    assign faddr_w = {code_w, frow_w};
    assign load_w  = (tick_w == TICK_W'(LOAD_TICK));

    vts_ram #(.AW(TXT_AW), .DW(CODE_W)) text_mem_i (
        .clk(clk), .we(text_we), .waddr(text_waddr), .wdata(text_wdata),
        .raddr(taddr_w), .rdata(code_w)
    );

    vts_ram #(.AW(FONT_AW), .DW(8)) font_mem_i (
        .clk(clk), .we(font_we), .waddr(font_waddr), .wdata(font_wdata),
        .raddr(faddr_w), .rdata(glyph_w)
    );

    vts_shifter #(.W(SLOT_PIX)) shifter_i (
        .clk(clk), .rst_n(rst_n), .load(load_w), .vis(vis_w),
        .glyph(glyph_w), .pixel(pixel)
    );
endmodule

// File: rtl/vts_checker.sv
module vts_checker #(
    parameter int H_TOTAL  = 100,
    parameter int HS_START = 82,
    parameter int LCW      = 8,
    localparam int HCW     = $clog2(H_TOTAL)
) (
    input logic           clk,
    input logic           rst_n,
    input logic [2:0]     tick,
    input logic [HCW-1:0] col,
    input logic [LCW:0]   lnum,
    input logic           vis,
    input logic           load,
    input logic           hsync_n,
    input logic           vsync_n,
    input logic           pixel
);
    AST_TICK_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick == 3'd7) |=> (tick == 3'd0)); // R2
    AST_COL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tick != 3'd7) |=> $stable(col)); // R2
    AST_HS_START: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hsync_n) |-> ((col == HCW'(HS_START)) && (tick == 3'd0))); // R3
    AST_LINE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !((tick == 3'd7) && (col == HCW'(H_TOTAL - 1))) |=> $stable(lnum)); // R4
    AST_VS_IN_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        !vsync_n |-> !vis); // R5
    AST_BLANK_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !vis) |=> !pixel); // R9
endmodule

bind vga_text_scan vts_checker #(
    .H_TOTAL(H_TOTAL), .HS_START(HS_START), .LCW(LCW)
) chk_i (
    .clk(clk), .rst_n(rst_n), .tick(tick_w), .col(col_w), .lnum(lnum_w),
    .vis(vis_w), .load(load_w), .hsync_n(hsync_n), .vsync_n(vsync_n),
    .pixel(pixel)
);

// File: tb/vga_text_scan_tb_top.sv
module vga_text_scan_tb_top;
    localparam int HT = 16, HV = 10, HSA = 12, HSB = 13;
    localparam int LCW = 5, P2L = 15, P3L = 5, VSA = 2, VSB = 3;
    localparam int VIS_L = 32 + P2L + 1;
    localparam int TOT_L = VIS_L + P3L + 1;
    localparam int FRAME = 8 * HT * TOT_L;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic text_we = 1'b0, font_we = 1'b0;
    logic [11:0] text_waddr = '0, font_waddr = '0;
    logic [7:0] text_wdata = '0, font_wdata = '0;
    logic hsync_n, vsync_n, pixel;

    int checks = 0, failures = 0;
    logic [7:0] txt_m [64];
    logic [7:0] fnt_m [4096];

    typedef struct { logic hs; logic vs; logic px; logic vis; } exp_t;
    exp_t sb_q[$];

    always #10 clk = ~clk;

    vga_text_scan #(
        .H_TOTAL(HT), .H_VIS(HV), .HS_START(HSA), .HS_END(HSB), .LCW(LCW),
        .P2_LAST(P2L), .P3_LAST(P3L), .VS_FIRST(VSA), .VS_LAST(VSB),
        .COL_BITS(4), .TXT_AW(12)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .text_we(text_we), .text_waddr(text_waddr),
        .text_wdata(text_wdata), .font_we(font_we), .font_waddr(font_waddr),
        .font_wdata(font_wdata), .hsync_n(hsync_n), .vsync_n(vsync_n), .pixel(pixel)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b time=%0t", req, act, exp, $time);
        end
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // driver: expected values per clock since reset release (R2..R9 model)
    task automatic push_expected(input int ncyc);
        for (int n = 0; n < ncyc; n++) begin
            exp_t e;
            int c, l, s, cs, ls, code;
            logic [7:0] g;
            c = (n / 8) % HT;
            l = (n / (8 * HT)) % TOT_L;
            e.hs = !(c >= HSA && c <= HSB);
            e.vs = !(l == VIS_L + VSA || l == VIS_L + VSB);
            e.px = 1'b0;
            e.vis = 1'b0;
            if (n >= 3) begin
                s  = (n - 3) / 8;
                cs = s % HT;
                ls = (s / HT) % TOT_L;
                if (cs < HV && ls < VIS_L) begin
                    e.vis = 1'b1;
                    code = int'(txt_m[(ls / 16) * 16 + cs]);
                    g = fnt_m[code * 16 + (ls % 16)];
                    e.px = g[7 - ((n - 3) % 8)];
                end
            end
            sb_q.push_back(e);
        end
    endtask

    // monitor: pops one expected item per clock, samples away from the edge
    task automatic run_monitor(input int ncyc);
        for (int n = 0; n < ncyc; n++) begin
            exp_t e;
            #1;
            e = sb_q.pop_front();
            check("R2/R3 hsync_n", hsync_n, e.hs);
            check("R4/R5 vsync_n", vsync_n, e.vs);
            if (e.vis) check("R6/R7/R8 pixel", pixel, e.px);
            else       check("R9 blanked pixel", pixel, 1'b0);
            @(negedge clk);
        end
    endtask

    task automatic reset_checks();
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); #1;
            check("R1 reset hsync_n", hsync_n, 1'b1);
            check("R1 reset vsync_n", vsync_n, 1'b1);
            check("R1 reset pixel", pixel, 1'b0);
        end
    endtask

    initial begin
        for (int a = 0; a < 64; a++) txt_m[a] = 8'((a * 29 + 5) & 255);
        for (int a = 0; a < 4096; a++) fnt_m[a] = 8'(((a * 73) ^ (a >> 4) ^ 8'h5A) & 255);
        for (int a = 0; a < 64; a++) begin
            @(negedge clk);
            text_we = 1'b1; text_waddr = 12'(a); text_wdata = txt_m[a];
        end
        @(negedge clk); text_we = 1'b0;
        for (int a = 0; a < 4096; a++) begin
            font_we = 1'b1; font_waddr = 12'(a); font_wdata = fnt_m[a];
            @(negedge clk);
        end
        font_we = 1'b0;
        reset_checks();
        // R1 R2 R3 R4 R5 R6 R7 R8 R9: two full frames from reset release
        push_expected(2 * FRAME + 50);
        @(negedge clk); rst_n = 1'b1;
        run_monitor(2 * FRAME + 50);
        // R1: reset in mid-frame, scan must restart at column 0 of line 0
        repeat (37) @(negedge clk);
        rst_n = 1'b0;
        reset_checks();
        push_expected(3 * 8 * HT + 20);
        @(negedge clk); rst_n = 1'b1;
        run_monitor(3 * 8 * HT + 20);
        report();
    end

    initial begin
        #(20ns * 150000);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        report();
    end
endmodule